// File: doc/BRIEF.md
# Two-Level Interrupt Aggregation Controller

The controller takes 32 level-sensitive second-level interrupt inputs, held as four 8-bit groups, and folds them into 12 first-level interrupt lines. Each group has a fixed idle pattern. An input counts as active when it differs from the idle bit at its position, so active-high and active-low sources can sit in the same group. Each active source then passes through a second-level mask. Each first-level line takes the union of a fixed set of bits from one group. That union is gated by a first-level mask, and the result drives a registered output.

A host reaches the block through a byte-wide register port. The port exposes the synchronized raw inputs, the six mask bytes and a query register. A host writes a first-level line number to the query register. One cycle later the register holds the lowest-numbered active, unmasked second-level source of that line. If no such source exists, it holds the line number itself and a flag that says no source was found.

Top module: `irq_agg_ctrl`

## Requirements
- R1: After reset, all six mask bytes read 0xFF, every bit of `l1_irq_o` is 0, the status bytes read 0x00 and the query register reads 0x80.
- R2: Register offsets: 0 to 3 are the status bytes for groups 0 to 3 and are read-only, so writes to them are ignored. 4 to 7 are the second-level mask bytes for groups 0 to 3. 8 and 9 are the first-level mask bytes: line k sits in byte 8 + k/8 at bit k%8. 10 is the query register. Every mask bit reads back as written, including the 4 unused bits of byte 9.
- R3: Status byte g shows `src_i[8g+7:8g]` after two clock edges (two-flop synchronizer). After one edge it still shows the previous value.
- R4: Source n sits in group n/8 at bit n%8. It is active when its synchronized input differs from its group's idle pattern. The idle patterns for groups 0 to 3 are 0x00, 0xBE, 0xFC and 0xF7.
- R5: In every mask register, a bit set to 1 disables the corresponding interrupt and a bit cleared to 0 enables it.
- R6: Line k is pending when any active, unmasked source of its group/bit set is present. The sets, written as line: group/bits, are: 0: 2/0x40, 1: 2/0x80, 2: 3/0x08, 3: 3/0x01, 4: 1/0x01, 5: 2/0x3C, 6: 1/0x3E, 7: 0/0xFF, 8: 1/0x40, 9: 1/0x80, 10: 3/0x06, 11: 2/0x03.
- R7: `l1_irq_o[k]` is registered and equals pending(k) AND NOT first-level mask bit k. It responds 3 edges after an input change and 1 edge after a mask write.
- R8: A write of line number L (below 12) to offset 10 loads the query register at that edge. The register then reads with bit 7 = 0 and bits 4:0 = 8·group + the lowest bit position within the line's active, unmasked set.
- R9: If line L has no active, unmasked source, or if L is 12 or more, the query register reads bit 7 = 1 and bits 4:0 = L[4:0].
- R10: Sources 28 to 31 belong to no line. They never affect `l1_irq_o` or a query result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Raw second-level interrupt levels, asynchronous |
| reg_addr_i | input | 4 | Register offset for read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i`, combinational |
| l1_irq_o | output | 12 | Registered first-level interrupt lines |

## Verification
Some properties are checked by assertions on every cycle. A set first-level mask bit forces its output low on the next cycle. A pending line's chosen source is active, and no lower bit in that line's set is active. Sources 28 to 31 never reach the fold logic. Other behaviours only the bench scenarios can show: that the group idle patterns and the line-to-bit sets are correct, the synchronizer and mask-write latencies, register readback and the query fallback encoding. The bench shows these by sweeping every single source toggle, querying every line, and running pseudo-random input and mask mixes against an arithmetic model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
   localparam int GRP_W    = 8;
   localparam int NUM_GRP  = 4;
   localparam int NUM_L1   = 12;
   localparam int USED_SRC = 28;

   // Per-group idle level; a source differing from it is active.
   function automatic logic [GRP_W-1:0] idle_pat(input int g);
      case (g)
         0:       idle_pat = 8'h00;
         1:       idle_pat = 8'hBE;
         2:       idle_pat = 8'hFC;
         3:       idle_pat = 8'hF7;
         default: idle_pat = 8'h00;
      endcase
   endfunction

   // Group feeding each first-level line.
   function automatic int l1_group(input int k);
      case (k)
         7:               l1_group = 0;
         4, 6, 8, 9:      l1_group = 1;
         0, 1, 5, 11:     l1_group = 2;
         default:         l1_group = 3;
      endcase
   endfunction

   // Bits of that group that belong to each first-level line.
   function automatic logic [GRP_W-1:0] l1_bits(input int k);
      case (k)
         0:       l1_bits = 8'h40;
         1:       l1_bits = 8'h80;
         2:       l1_bits = 8'h08;
         3:       l1_bits = 8'h01;
         4:       l1_bits = 8'h01;
         5:       l1_bits = 8'h3C;
         6:       l1_bits = 8'h3E;
         7:       l1_bits = 8'hFF;
         8:       l1_bits = 8'h40;
         9:       l1_bits = 8'h80;
         10:      l1_bits = 8'h06;
         11:      l1_bits = 8'h03;
         default: l1_bits = 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] meta_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         q_o    <= '0;
      end else begin
         meta_q <= d_i;
         q_o    <= meta_q;
      end
   end
endmodule

// File: rtl/irq_l2_stage.sv
module irq_l2_stage
   import irq_agg_pkg::*;
#(
   parameter int NGRP  = NUM_GRP,
   parameter int GW    = GRP_W,
   parameter int NUSED = USED_SRC,
   localparam int NSRC = NGRP * GW
) (
   input  logic [NSRC-1:0] raw_i,
   input  logic [NSRC-1:0] mask_i,
   output logic [NSRC-1:0] act_o
);
   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      localparam logic [GW-1:0] IDLE = GW'(idle_pat(g));
      logic [GW-1:0] used;
      for (genvar b = 0; b < GW; b++) begin : g_bit
         assign used[b] = ((g * GW + b) < NUSED);
      end
      assign act_o[g*GW +: GW] = (raw_i[g*GW +: GW] ^ IDLE) & ~mask_i[g*GW +: GW] & used;
   end
endmodule

// File: rtl/irq_l1_fold.sv
module irq_l1_fold
   import irq_agg_pkg::*;
#(
   parameter int NGRP  = NUM_GRP,
   parameter int GW    = GRP_W,
   parameter int NL1   = NUM_L1,
   parameter int NUSED = USED_SRC,
   localparam int NSRC = NGRP * GW,
   localparam int IDXW = $clog2(NSRC),
   localparam int LOWW = $clog2(GW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   act_i,
   output logic [NL1-1:0]    pend_o,
   output logic [NL1*IDXW-1:0] idx_o
);
   for (genvar k = 0; k < NL1; k++) begin : g_line
      localparam int            GSEL = l1_group(k);
      localparam logic [GW-1:0] BSEL = GW'(l1_bits(k));
      logic [GW-1:0]   sel;
      logic [LOWW-1:0] low;

      assign sel = act_i[GSEL*GW +: GW] & BSEL;

      always_comb begin
         low = '0;
         for (int b = GW - 1; b >= 0; b--) begin
            if (sel[b]) low = LOWW'(b);
         end
      end

      assign pend_o[k]              = |sel;
      assign idx_o[k*IDXW +: IDXW] = IDXW'(GSEL * GW) + IDXW'(low);

      // R8: reported source is really active
      assert_pick_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pend_o[k] |-> act_i[idx_o[k*IDXW +: IDXW]]);
      // R8: nothing lower in the line's set is active
      assert_pick_lowest_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pend_o[k] |-> ((act_i[GSEL*GW +: GW] & BSEL &
                         ((GW'(1) << idx_o[k*IDXW +: LOWW]) - GW'(1))) == '0));
   end

   if (NUSED < NSRC) begin : g_unused_chk
      // R10: unused sources never arrive here
      assert_unused_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
         act_i[NSRC-1:NUSED] == '0);
   end
endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
   import irq_agg_pkg::*;
#(
   parameter int NGRP   = NUM_GRP,
   parameter int GW     = GRP_W,
   parameter int NL1    = NUM_L1,
   parameter int NUSED  = USED_SRC,
   parameter int ADDR_W = 4,
   localparam int NSRC  = NGRP * GW,
   localparam int IDXW  = $clog2(NSRC),
   localparam int L1REG = (NL1 + GW - 1) / GW,
   localparam int STAT_BASE = 0,
   localparam int L2M_BASE  = NGRP,
   localparam int L1M_BASE  = 2 * NGRP,
   localparam int QRY_ADDR  = 2 * NGRP + L1REG
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [31:0]       src_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [7:0]        reg_wdata_i,
   input  logic              reg_we_i,
   output logic [7:0]        reg_rdata_o,
   output logic [11:0]       l1_irq_o
);
   if (NGRP != NUM_GRP || GW != GRP_W || NL1 != NUM_L1) begin : g_bad_tables
      $error("irq_agg_ctrl: line tables are fixed at 4 groups, 8 bits, 12 lines");
   end
   if (QRY_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_agg_ctrl: ADDR_W too small for register map");
   end
   if (IDXW + 1 > GW) begin : g_bad_qry
      $error("irq_agg_ctrl: query byte cannot hold index and flag");
   end

   logic [NSRC-1:0]     raw_s;
   logic [NSRC-1:0]     act;
   logic [NSRC-1:0]     l2_mask_q;
   logic [L1REG*GW-1:0] l1_mask_q;
   logic [NL1-1:0]      pend;
   logic [NL1*IDXW-1:0] idx;
   logic [GW-1:0]       qry_q;
   logic [GW-1:0]       qry_d;
   logic                hit;
   logic [IDXW-1:0]     hit_idx;

   irq_sync #(.W(NSRC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (src_i),
      .q_o   (raw_s)
   );

   irq_l2_stage #(.NGRP(NGRP), .GW(GW), .NUSED(NUSED)) u_l2 (
      .raw_i  (raw_s),
      .mask_i (l2_mask_q),
      .act_o  (act)
   );

   irq_l1_fold #(.NGRP(NGRP), .GW(GW), .NL1(NL1), .NUSED(NUSED)) u_fold (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (act),
      .pend_o (pend),
      .idx_o  (idx)
   );

   // Query lookup for the line number on the write bus
   always_comb begin
      hit     = 1'b0;
      hit_idx = '0;
      for (int k = 0; k < NL1; k++) begin
         if (reg_wdata_i == GW'(k)) begin
            hit     = pend[k];
            hit_idx = idx[k*IDXW +: IDXW];
         end
      end
      if (hit) qry_d = {1'b0, {(GW-1-IDXW){1'b0}}, hit_idx};
      else     qry_d = {1'b1, {(GW-1-IDXW){1'b0}}, reg_wdata_i[IDXW-1:0]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l2_mask_q <= '1;
         l1_mask_q <= '1;
         qry_q     <= {1'b1, {(GW-1){1'b0}}};
         l1_irq_o  <= '0;
      end else begin
         l1_irq_o <= pend & ~l1_mask_q[NL1-1:0];
         if (reg_we_i) begin
            for (int g = 0; g < NGRP; g++) begin
               if (reg_addr_i == ADDR_W'(L2M_BASE + g))
                  l2_mask_q[g*GW +: GW] <= reg_wdata_i;
            end
            for (int r = 0; r < L1REG; r++) begin
               if (reg_addr_i == ADDR_W'(L1M_BASE + r))
                  l1_mask_q[r*GW +: GW] <= reg_wdata_i;
            end
            if (reg_addr_i == ADDR_W'(QRY_ADDR)) qry_q <= qry_d;
         end
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      for (int g = 0; g < NGRP; g++) begin
         if (reg_addr_i == ADDR_W'(STAT_BASE + g)) reg_rdata_o = raw_s[g*GW +: GW];
         if (reg_addr_i == ADDR_W'(L2M_BASE + g))  reg_rdata_o = l2_mask_q[g*GW +: GW];
      end
      for (int r = 0; r < L1REG; r++) begin
         if (reg_addr_i == ADDR_W'(L1M_BASE + r)) reg_rdata_o = l1_mask_q[r*GW +: GW];
      end
      if (reg_addr_i == ADDR_W'(QRY_ADDR)) reg_rdata_o = qry_q;
   end

   for (genvar k = 0; k < NL1; k++) begin : g_mask_chk
      // R7: a disabled line is low on the following cycle
      assert_masked_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
         l1_mask_q[k] |=> !l1_irq_o[k]);
   end
endmodule

// File: tb/irq_agg_ctrl_bench.sv
module irq_agg_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = 32'h0;
   logic [3:0]  addr = 4'h0;
   logic [7:0]  wdata = 8'h0;
   logic        we = 1'b0;
   logic [7:0]  rdata;
   logic [11:0] l1;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [31:0] l2m_m = '1;
   logic [15:0] l1m_m = '1;

   always #4 clk = ~clk;

   irq_agg_ctrl u_irq_agg_ctrl (
      .clk(clk), .rst_n(rst_n), .src_i(src), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_we_i(we), .reg_rdata_o(rdata), .l1_irq_o(l1)
   );

   function automatic logic [7:0] m_idle(int g);
      case (g) 0: return 8'h00; 1: return 8'hBE; 2: return 8'hFC; default: return 8'hF7; endcase
   endfunction
   function automatic int m_grp(int k);
      int t[12] = '{2,2,3,3,1,2,1,0,1,1,3,2};
      return t[k];
   endfunction
   function automatic logic [7:0] m_bits(int k);
      logic [7:0] t[12] = '{8'h40,8'h80,8'h08,8'h01,8'h01,8'h3C,8'h3E,8'hFF,8'h40,8'h80,8'h06,8'h03};
      return t[k];
   endfunction
   function automatic logic [31:0] m_idle_all();
      return {m_idle(3), m_idle(2), m_idle(1), m_idle(0)};
   endfunction
   function automatic logic [31:0] m_act(logic [31:0] s, logic [31:0] m);
      return (s ^ m_idle_all()) & ~m & 32'h0FFF_FFFF;
   endfunction
   function automatic logic [7:0] m_sel(int k, logic [31:0] s, logic [31:0] m);
      logic [31:0] a = m_act(s, m);
      return a[m_grp(k)*8 +: 8] & m_bits(k);
   endfunction
   function automatic logic [11:0] m_l1(logic [31:0] s, logic [31:0] m, logic [15:0] lm);
      logic [11:0] r;
      for (int k = 0; k < 12; k++) r[k] = (m_sel(k, s, m) != 0) && !lm[k];
      return r;
   endfunction
   function automatic logic [7:0] m_qry(int line, logic [31:0] s, logic [31:0] m);
      logic [7:0] sel;
      if (line >= 12) return 8'h80 | 8'(line & 31);
      sel = m_sel(line, s, m);
      if (sel == 0) return 8'h80 | 8'(line);
      for (int b = 0; b < 8; b++) if (sel[b]) return 8'(m_grp(line) * 8 + b);
      return 8'hxx;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [7:0] d);
      @(posedge clk); #1;
      addr = 4'(a); wdata = d; we = 1'b1;
      @(posedge clk); #1;
      we = 1'b0;
   endtask

   task automatic rd(int a, output logic [7:0] d);
      addr = 4'(a); #1;
      d = rdata;
   endtask

   task automatic set_masks(logic [31:0] m, logic [15:0] lm);
      for (int g = 0; g < 4; g++) wr(4 + g, m[g*8 +: 8]);
      wr(8, lm[7:0]);
      wr(9, lm[15:8]);
      l2m_m = m; l1m_m = lm;
   endtask

   task automatic settle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_all_queries(string req);
      logic [7:0] d;
      for (int line = 0; line < 14; line++) begin
         wr(10, 8'(line));
         rd(10, d);
         check(req, d, m_qry(line, src, l2m_m));
      end
   endtask

   initial begin
      #(8 * 200000);
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [31:0] x;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle(1);

      // R1 reset state
      check("R1 l1 reset", l1, 0);
      for (int a = 4; a < 10; a++) begin rd(a, d); check("R1 mask reset", d, 8'hFF); end
      rd(0, d); check("R1 status reset", d, 0);
      rd(10, d); check("R1 query reset", d, 8'h80);

      // R2 readback, read-only status, unused L1 bits
      wr(4, 8'h5A); wr(7, 8'hC3); wr(9, 8'hF3);
      rd(4, d); check("R2 l2 mask readback", d, 8'h5A);
      rd(7, d); check("R2 l2 mask readback", d, 8'hC3);
      rd(9, d); check("R2 unused l1 bits readback", d, 8'hF3);
      wr(0, 8'hFF); wr(3, 8'hAA);
      rd(0, d); check("R2 status write ignored", d, 8'h00);
      rd(3, d); check("R2 status write ignored", d, 8'h00);

      // R3 synchronizer latency, R7 input latency
      set_masks(32'h0, 16'h0);
      src = m_idle_all();
      settle(4);
      check("R7 idle no irq", l1, 0);
      @(posedge clk); #1 src = m_idle_all() ^ 32'h0000_0001;
      settle(1);
      rd(0, d); check("R3 status after one edge", d, 8'h00);
      check("R7 l1 after one edge", l1, 0);
      settle(1);
      rd(0, d); check("R3 status after two edges", d, 8'h01);
      check("R7 l1 after two edges", l1, 0);
      settle(1);
      check("R7 l1 after three edges", l1, 12'h080);

      // R7 mask write latency
      @(posedge clk); #1 addr = 4'd8; wdata = 8'h80; we = 1'b1;
      @(posedge clk); #1 we = 1'b0;
      check("R7 l1 at mask write edge", l1, 12'h080);
      settle(1);
      check("R7 l1 one edge after mask write", l1, 12'h000);
      set_masks(32'h0, 16'h0);

      // R4 R6 R8 R9 R10: single-source sweep
      for (int n = 0; n < 32; n++) begin
         src = m_idle_all() ^ (32'h1 << n);
         settle(4);
         if (n >= 28) check("R10 unused source quiet", l1, 0);
         else         check("R6 single source l1", l1, m_l1(src, l2m_m, l1m_m));
         check_all_queries(n >= 28 ? "R10 query" : "R8 R9 query sweep");
      end

      // R5 R7 R8: mixed inputs and masks
      x = 32'h1234_5678;
      for (int it = 0; it < 40; it++) begin
         logic [31:0] m;
         logic [15:0] lm;
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         src = x;
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         m = (it < 10) ? 32'h0 : (x & {x[15:0], x[31:16]});
         x ^= x << 13; x ^= x >> 17; x ^= x << 5;
         lm = (it % 3 == 0) ? 16'h0 : x[15:0];
         set_masks(m, lm);
         settle(4);
         check("R5 R7 mixed l1", l1, m_l1(src, l2m_m, l1m_m));
         check_all_queries("R5 R8 mixed query");
      end

      // R5: all second-level masked, everything falls back
      set_masks(32'hFFFF_FFFF, 16'h0);
      src = ~m_idle_all();
      settle(4);
      check("R5 all l2 masked", l1, 0);
      check_all_queries("R9 masked fallback");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule